// File: doc/BRIEF.md
# Serial Peripheral Slave with Queued Transmit

This block is the target end of a serial peripheral link. It never starts a transfer. An external master supplies the serial clock. The block samples that clock, the select line and the data input into the system clock domain, and every action it takes follows a detected clock edge. Data moves most significant bit first. The clock idles low, incoming data is sampled on each rising edge, and the outgoing bit advances on each falling edge. The first bit of a byte is on the output before the first rising edge.

On the outgoing side, a one-byte holding stage sits in front of the shift register. Software can load the next byte while the current one is still moving. When the current byte ends, the held byte moves into the shift register and waits there for the master. If no byte is held at that point, the last byte is sent again. On the incoming side, each finished byte is copied into a receive register and a completion flag is raised. A select-ignore input picks between selected (4-wire) operation and always-active (3-wire) operation. An output-disable input gives up the data output, so that several targets can share one return line.

Top module: `spi_slave_buf`

## Requirements
- R1: After reset, done_flag is 0, txe_flag is 1, irq is 0 and rx_data is 0. With sel_ignore low and ss_n high, miso_oe is 0.
- R2: With SCK idling low, MOSI is captured MSB first on rising edges and MISO presents bit 7 first, then advances on falling edges. After the eighth rising edge, rx_data holds the received byte and done_flag is 1.
- R3: A done_clr pulse clears done_flag. If done_clr arrives in the same cycle as a byte completion, done_flag stays 1.
- R4: A write that arrives while no byte is in progress and the shift register holds no unsent byte goes directly into the shift register. txe_flag does not change.
- R5: A write that arrives while a byte is in progress, or while an unsent byte waits in the shift register, goes to the holding stage and clears txe_flag. At the next byte completion the held byte moves into the shift register and txe_flag becomes 1.
- R6: A txe_clr pulse clears txe_flag.
- R7: When a byte completes and no byte is held, the next transfer resends the same byte.
- R8: With sel_ignore low, the block is active only while ss_n is low. While ss_n is high, miso_oe is 0 and SCK edges change nothing.
- R9: If ss_n rises in the middle of a byte with sel_ignore low, the partial byte is dropped and done_flag is not set. The next transfer starts again from bit 7 of the byte that was in the shift register.
- R10: With sel_ignore high, ss_n is ignored and the block shifts and drives MISO whatever the level of ss_n.
- R11: While out_disable is high, miso_oe is 0 in both modes.
- R12: irq equals irq_en AND (done_flag OR (enh_en AND txe_flag)).
- R13: A write in the same cycle as a byte completion behaves as follows. If a byte is held, the held byte goes to the shift register, the new byte is held and txe_flag is 0. If no byte is held, the new byte goes directly to the shift register and txe_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso (0 = high impedance) |
| tx_wr | input | 1 | One-cycle write strobe for the next outgoing byte |
| tx_wdata | input | DATA_W | Byte to send |
| rx_data | output | DATA_W | Last byte received |
| done_flag | output | 1 | Transfer-complete flag |
| done_clr | input | 1 | Clears done_flag |
| txe_flag | output | 1 | Transmit-holding-empty flag |
| txe_clr | input | 1 | Clears txe_flag |
| sel_ignore | input | 1 | 1 = ignore ss_n (3-wire) |
| out_disable | input | 1 | 1 = keep miso high impedance |
| irq_en | input | 1 | Interrupt enable |
| enh_en | input | 1 | Lets txe_flag raise irq |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same system cycle: a byte completion, and a software action on the transmit path or the flags. Both a transmit write and a done_clr can coincide with the completion. The bench counts the synchronizer and edge-detect stages from the moment it drives the eighth rising SCK edge. It then pulses the strobe in exactly the cycle in which the design sees that edge. The outcome is judged from the order in which bytes come back out on MISO and from the flag values. Both cases are covered: a byte already held, and an empty holding stage.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  // Flag update: set has priority over clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Interrupt request from the flags and enables.
  function automatic logic irq_calc(input logic ien, input logic enh,
                                    input logic done, input logic txe);
    return ien & (done | (enh & txe));
  endfunction

  // Slave is live when select is ignored or select is asserted.
  function automatic logic is_active(input logic ign, input logic sel_n);
    return ign | ~sel_n;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= din;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = st[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         miso_bit,
  output logic         byte_done,
  output logic [W-1:0] rx_word,
  output logic         mid_byte
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic          sck_prev;
  logic          sck_rise, sck_fall;
  logic [CW-1:0] cnt;
  logic [W-2:0]  rx_sh;
  logic [W-1:0]  tx_sh, cur, next_cur;

  assign sck_rise  = sck_s & ~sck_prev;
  assign sck_fall  = ~sck_s & sck_prev;
  assign byte_done = active & sck_rise & (cnt == LAST);
  assign rx_word   = {rx_sh, mosi_s};
  assign mid_byte  = (cnt != '0);
  assign miso_bit  = tx_sh[W-1];
  assign next_cur  = load ? load_data : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      cur      <= '0;
    end else begin
      sck_prev <= sck_s;
      cur      <= next_cur;
      if (!active) begin
        cnt   <= '0;
        rx_sh <= '0;
        tx_sh <= next_cur;
      end else begin
        if (sck_rise) begin
          rx_sh <= rx_word[W-2:0];
          cnt   <= byte_done ? '0 : cnt + 1'b1;
        end
        if (byte_done || load) tx_sh <= next_cur;
        else if (sck_fall && mid_byte) tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_tx_queue.sv
module spi_tx_queue
  import spi_slave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_wdata,
  input  logic         txe_clr,
  input  logic         byte_done,
  input  logic         mid_byte,
  output logic         load,
  output logic [W-1:0] load_data,
  output logic         txe,
  output logic         sh_full,
  output logic         hold_full
);
  logic [W-1:0] hold_q, hold_n;
  logic         hold_full_n, sh_full_n, to_hold, drain;

  always_comb begin
    load        = 1'b0;
    load_data   = hold_q;
    hold_n      = hold_q;
    hold_full_n = hold_full;
    sh_full_n   = sh_full;
    to_hold     = 1'b0;
    drain       = 1'b0;
    if (byte_done) begin
      if (hold_full) begin
        load      = 1'b1;
        sh_full_n = 1'b1;
        if (tx_wr) begin
          hold_n  = tx_wdata;
          to_hold = 1'b1;
        end else begin
          hold_full_n = 1'b0;
          drain       = 1'b1;
        end
      end else if (tx_wr) begin
        load      = 1'b1;
        load_data = tx_wdata;
        sh_full_n = 1'b1;
      end else begin
        sh_full_n = 1'b0;
      end
    end else if (tx_wr) begin
      if (!sh_full && !mid_byte) begin
        load      = 1'b1;
        load_data = tx_wdata;
        sh_full_n = 1'b1;
      end else begin
        hold_n      = tx_wdata;
        hold_full_n = 1'b1;
        to_hold     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_full   <= 1'b0;
      txe       <= 1'b1;
    end else begin
      hold_q    <= hold_n;
      hold_full <= hold_full_n;
      sh_full   <= sh_full_n;
      txe       <= flag_next(txe, drain, txe_clr | to_hold);
    end
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              done_flag,
  input  logic              done_clr,
  output logic              txe_flag,
  input  logic              txe_clr,
  input  logic              sel_ignore,
  input  logic              out_disable,
  input  logic              irq_en,
  input  logic              enh_en,
  output logic              irq
);
  logic [2:0]        sync_out;
  logic              sck_s, mosi_s, ss_s;
  logic              active, byte_done, mid_byte, load, sh_full, hold_full;
  logic [DATA_W-1:0] load_data, rx_word;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ss_n, mosi, sck}), .dout(sync_out)
  );
  assign {ss_s, mosi_s, sck_s} = sync_out;

  assign active = is_active(sel_ignore, ss_s);

  spi_bit_engine #(.W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .active(active), .sck_s(sck_s), .mosi_s(mosi_s),
    .load(load), .load_data(load_data), .miso_bit(miso), .byte_done(byte_done),
    .rx_word(rx_word), .mid_byte(mid_byte)
  );

  spi_tx_queue #(.W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .txe_clr(txe_clr),
    .byte_done(byte_done), .mid_byte(mid_byte), .load(load), .load_data(load_data),
    .txe(txe_flag), .sh_full(sh_full), .hold_full(hold_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (byte_done) rx_data <= rx_word;
      done_flag <= flag_next(done_flag, byte_done, done_clr);
    end
  end

  assign miso_oe = active & ~out_disable;
  assign irq     = irq_calc(irq_en, enh_en, done_flag, txe_flag);
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_done,
  input logic              load,
  input logic              sh_full,
  input logic              hold_full,
  input logic              mid_byte,
  input logic              active,
  input logic              tx_wr,
  input logic              txe_flag,
  input logic              done_flag,
  input logic              done_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] rx_word,
  input logic              out_disable,
  input logic              miso_oe,
  input logic              irq,
  input logic              irq_en
);
  // R2
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_flag);
  // R2
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (rx_data == $past(rx_word)));
  // R3
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !byte_done) |=> !done_flag);
  // R5
  hold_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !byte_done && (sh_full || mid_byte)) |=> !txe_flag);
  // R13
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && hold_full) |=> sh_full);
  // R7
  retx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !load) |=> !sh_full);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !mid_byte);
  // R11
  dis_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> !miso_oe);
  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
endmodule

bind spi_slave_buf spi_slave_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .load(load), .sh_full(sh_full),
  .hold_full(hold_full), .mid_byte(mid_byte), .active(active), .tx_wr(tx_wr),
  .txe_flag(txe_flag), .done_flag(done_flag), .done_clr(done_clr), .rx_data(rx_data),
  .rx_word(rx_word), .out_disable(out_disable), .miso_oe(miso_oe), .irq(irq),
  .irq_en(irq_en)
);

// File: tb/tb_spi_slave_buf.sv
`timescale 1ns/1ps
module tb_spi_slave_buf;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0;
  logic sck = 0, ss_n = 1, mosi = 0;
  logic miso, miso_oe;
  logic tx_wr = 0; logic [7:0] tx_wdata = 0;
  logic [7:0] rx_data;
  logic done_flag, done_clr = 0, txe_flag, txe_clr = 0;
  logic sel_ignore = 0, out_disable = 0, irq_en = 0, enh_en = 0, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_slave_buf dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_data(rx_data),
    .done_flag(done_flag), .done_clr(done_clr), .txe_flag(txe_flag), .txe_clr(txe_clr),
    .sel_ignore(sel_ignore), .out_disable(out_disable), .irq_en(irq_en),
    .enh_en(enh_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); tx_wr = 1; tx_wdata = d;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic pulse_done_clr();
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
  endtask

  task automatic pulse_txe_clr();
    @(negedge clk); txe_clr = 1; @(negedge clk); txe_clr = 0;
  endtask

  // One byte; optional write mid-byte, optional write and/or done_clr in the completion cycle.
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input int mid_bit,
                      input logic [7:0] mid_d, input bit end_wr, input logic [7:0] end_d,
                      input bit end_clr);
    mi = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); mosi = mo[7-i];
      idle(HP);
      mi[7-i] = miso;
      sck = 1;
      if (i == 7 && (end_wr || end_clr)) begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        tx_wr = end_wr; tx_wdata = end_d; done_clr = end_clr;
        @(negedge clk);
        tx_wr = 0; done_clr = 0;
        idle(HP - 3);
      end else begin
        if (i == mid_bit) begin
          idle(2);
          tx_wr = 1; tx_wdata = mid_d;
          @(negedge clk); tx_wr = 0;
          idle(HP - 3);
        end else idle(HP);
      end
      sck = 0;
    end
    idle(HP);
  endtask

  task automatic xfer_plain(input logic [7:0] mo, output logic [7:0] mi);
    xfer(mo, mi, -1, 8'h00, 0, 8'h00, 0);
  endtask

  task automatic partial(input logic [7:0] mo, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); mosi = mo[7-i];
      idle(HP); sck = 1; idle(HP); sck = 0;
    end
    idle(HP);
  endtask

  task automatic t_reset();
    chk("R1 done", done_flag, 0);
    chk("R1 txe", txe_flag, 1);
    chk("R1 irq", irq, 0);
    chk("R1 rx", rx_data, 0);
    chk("R1 oe", miso_oe, 0);
  endtask

  task automatic t_basic();
    logic [7:0] got;
    ss_n = 0; idle(4);
    chk("R8 oe selected", miso_oe, 1);
    write_byte(8'hA5); idle(2);
    chk("R4 txe unchanged", txe_flag, 1);
    xfer_plain(8'h3C, got);
    chk("R2 miso", got, 8'hA5);
    chk("R2 rx", rx_data, 8'h3C);
    chk("R2 done", done_flag, 1);
    chk("R12 irq off", irq, 0);
    irq_en = 1; idle(1);
    chk("R12 irq done", irq, 1);
    pulse_done_clr(); idle(1);
    chk("R3 clr", done_flag, 0);
    chk("R12 irq no enh", irq, 0);
    enh_en = 1; idle(1);
    chk("R12 irq txe", irq, 1);
    pulse_txe_clr(); idle(1);
    chk("R6 txe clr", txe_flag, 0);
    chk("R12 irq low", irq, 0);
    irq_en = 0; enh_en = 0;
  endtask

  task automatic t_queue();
    logic [7:0] got;
    write_byte(8'h11); idle(2);
    xfer(8'h5A, got, 3, 8'h22, 0, 8'h00, 0);
    chk("R5 first out", got, 8'h11);
    chk("R5 txe after drain", txe_flag, 1);
    chk("R2 rx 5A", rx_data, 8'h5A);
    xfer_plain(8'h00, got);
    chk("R5 queued out", got, 8'h22);
    xfer_plain(8'hFF, got);
    chk("R7 resend", got, 8'h22);
    chk("R2 rx FF", rx_data, 8'hFF);
  endtask

  task automatic t_collide();
    logic [7:0] got;
    write_byte(8'h33);
    write_byte(8'h44); idle(1);
    chk("R5 held txe", txe_flag, 0);
    xfer(8'h01, got, -1, 8'h00, 1, 8'h55, 0);
    chk("R13 held case out", got, 8'h33);
    chk("R13 held case txe", txe_flag, 0);
    xfer_plain(8'h02, got);
    chk("R13 held moved", got, 8'h44);
    chk("R5 txe set", txe_flag, 1);
    xfer_plain(8'h03, got);
    chk("R13 new held", got, 8'h55);
    // empty holding stage: write lands directly; also done_clr in the completion cycle
    xfer(8'h04, got, -1, 8'h00, 1, 8'h66, 1);
    chk("R7 resend 55", got, 8'h55);
    chk("R13 empty txe", txe_flag, 1);
    chk("R3 set wins", done_flag, 1);
    xfer_plain(8'h05, got);
    chk("R13 direct", got, 8'h66);
  endtask

  task automatic t_abort();
    logic [7:0] got;
    pulse_done_clr();
    ss_n = 1; idle(4);
    chk("R8 oe off", miso_oe, 0);
    partial(8'hC3, 8);
    chk("R8 no done", done_flag, 0);
    chk("R8 rx kept", rx_data, 8'h05);
    ss_n = 0; idle(4);
    partial(8'hF0, 3);
    ss_n = 1; idle(4);
    chk("R9 no done", done_flag, 0);
    ss_n = 0; idle(4);
    xfer_plain(8'h96, got);
    chk("R9 restart out", got, 8'h66);
    chk("R9 restart rx", rx_data, 8'h96);
  endtask

  task automatic t_modes();
    logic [7:0] got;
    ss_n = 1; sel_ignore = 1; idle(4);
    chk("R10 oe", miso_oe, 1);
    write_byte(8'h7E); idle(2);
    xfer_plain(8'h81, got);
    chk("R10 out", got, 8'h7E);
    chk("R10 rx", rx_data, 8'h81);
    out_disable = 1; idle(2);
    chk("R11 oe 3wire", miso_oe, 0);
    sel_ignore = 0; ss_n = 0; idle(4);
    chk("R11 oe 4wire", miso_oe, 0);
    out_disable = 0; idle(2);
    chk("R8 oe back", miso_oe, 1);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(3);
    t_reset();
    t_basic();
    t_queue();
    t_collide();
    t_abort();
    t_modes();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule